// File: doc/BRIEF.md
# Vector Branch Condition Evaluator

This block resolves conditional branches that test a 128-bit vector register in a scalar pipeline. Decode hands it the vector operand as a low and a high 64-bit half, a 2-bit branch kind, a 2-bit element format, a 10-bit signed word offset and the PC of the branch. It also takes four status bits: vector unit enabled, FPU enabled, FPU in 64-bit register mode, and "this branch sits in a delay slot". It returns a taken decision, the branch target, a one-instruction delay-slot request, and two mutually exclusive exception flags.

Two kinds test the whole vector for zero or nonzero. The other two test individual lanes whose width is 8, 16, 32 or 64 bits. A zero lane is found without one comparator per lane. Each half computes `(x - LSBS) & ~x & MSBS`, where LSBS has a one in the lowest bit of every lane and MSBS has a one in the top bit of every lane. A nonzero result in either half means that some lane is zero.

The parameter `OUT_REG` selects the variant. With 0, the decision is purely combinational and `res_valid` mirrors the decode strobe. With 1, the decision is captured on the strobe and presented one cycle later.

Top module: `vbr_cond_eval`

## Requirements
- R1: Branch kind 0 (whole-vector zero) is taken exactly when all 128 operand bits are zero.
- R2: Branch kind 1 (whole-vector nonzero) is taken exactly when at least one operand bit is set.
- R3: Branch kind 2 (some lane zero) is taken when at least one lane is all zeros. The lane width is 8 shifted left by the format code, so format 0, 1, 2 and 3 give 8, 16, 32 and 64 bits.
- R4: Branch kind 3 (every lane nonzero) is taken only when no lane of the selected width is all zeros.
- R5: The target equals PC + 4 + (sign-extended offset × 4), computed modulo 2^32.
- R6: When the FPU is enabled but not in 64-bit register mode, exc_rsvd is raised. This check has the highest priority.
- R7: When the FPU-mode check passes and the vector unit is disabled, exc_vudis is raised and exc_rsvd is not.
- R8: When the FPU-mode and unit checks pass and the branch sits in a delay slot, exc_rsvd is raised.
- R9: At most one exception flag is high, and whenever one is high, br_taken and dslot_req are low.
- R10: A branch that raises no exception sets dslot_req, whether or not it is taken.
- R11: With OUT_REG=0, res_valid equals dec_stb and the other outputs follow the inputs in the same cycle. With OUT_REG=1, res_valid is high in the cycle after dec_stb, and the outputs then reflect the inputs present at the strobe.
- R12: With OUT_REG=1, a synchronous active-low reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the registered variant) |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_stb | input | 1 | Decode strobe: a vector branch is presented |
| vec_lo | input | 64 | Operand bits 63..0 |
| vec_hi | input | 64 | Operand bits 127..64 |
| br_kind | input | 2 | 0 vector zero, 1 vector nonzero, 2 some lane zero, 3 all lanes nonzero |
| elem_fmt | input | 2 | Lane width code: 0 byte, 1 half, 2 word, 3 double |
| br_off | input | 10 | Signed word offset |
| pc | input | 32 | Address of the branch |
| vu_en | input | 1 | Vector unit enabled |
| fpu_en | input | 1 | FPU enabled |
| fpu_64 | input | 1 | FPU in 64-bit register mode |
| in_dslot | input | 1 | Branch is itself in a delay slot |
| res_valid | output | 1 | Result valid |
| br_taken | output | 1 | Branch condition holds |
| br_target | output | 32 | Branch target address |
| dslot_req | output | 1 | Execute one delay-slot instruction |
| exc_rsvd | output | 1 | Reserved-instruction exception |
| exc_vudis | output | 1 | Vector-unit-disabled exception |

## Verification
The bench builds the block twice with the default widths: instance u0 with OUT_REG=1 and u1 with OUT_REG=0. The same stimulus therefore checks both the same-cycle path and the one-cycle capture path.

Operands are drawn so that whole lanes of zero bytes are common. This exercises the borrow chain of the lane test at every format, including a zero lane sitting below nonzero lanes. The offset extremes and a PC next to the top of the address space bring the sign extension and the wrap of the target sum within reach.

// File: rtl/vbr_pkg.sv
`timescale 1ns/1ps
// Shared types for the vector branch evaluator.
// Assumes the branch-kind encoding below is produced by decode.
package vbr_pkg;
    typedef enum logic [1:0] {
        BK_VEC_ZERO   = 2'd0,
        BK_VEC_NZ     = 2'd1,
        BK_LANE_ZERO  = 2'd2,
        BK_LANE_ALLNZ = 2'd3
    } br_kind_e;

    localparam int NUM_FMT = 4;

    typedef struct packed {
        logic taken;
        logic dslot;
        logic rsvd;
        logic vudis;
    } br_flags_t;
endpackage

// File: rtl/vbr_lane_zero.sv
`timescale 1ns/1ps
// Zero-lane detector for one operand half.
// For each lane width it applies (x - LSBS) & ~x & MSBS and reduces the
// result. Only "any lane zero" is reported; this is exact even though lanes
// above a zero lane may show spurious borrow bits.
// Assumes HALF_W is a multiple of the widest lane (64 bits).
module vbr_lane_zero #(
    parameter int HALF_W = 64
) (
    input  logic [HALF_W-1:0] half,
    input  logic [1:0]        fmt,
    output logic              any_zero
);
    import vbr_pkg::*;

    // Build a mask with a one at the lowest bit of every lane of width w.
    function automatic logic [HALF_W-1:0] lsb_mask(input int w);
        logic [HALF_W-1:0] m;
        m = '0;
        for (int i = 0; i < HALF_W; i++) begin
            if (i % w == 0) m[i] = 1'b1;
        end
        return m;
    endfunction

    logic [NUM_FMT-1:0] hit;

    for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
        localparam int LANE_W = 8 << f;
        localparam logic [HALF_W-1:0] LSBS = lsb_mask(LANE_W);
        localparam logic [HALF_W-1:0] MSBS = LSBS << (LANE_W - 1);
        logic [HALF_W-1:0] diff;
        // Subtract one from every lane at once and keep borrowed top bits.
        always_comb begin
            diff   = half - LSBS;
            hit[f] = |(diff & ~half & MSBS);
        end
    end

    // Select the detector that matches the requested format.
    always_comb any_zero = hit[fmt];
endmodule

// File: rtl/vbr_guard.sv
`timescale 1ns/1ps
// Legality checks applied ahead of the branch decision.
// Priority: FPU mode, then vector unit enable, then delay-slot position.
// The outputs are one-hot or all zero.
module vbr_guard (
    input  logic fpu_en,
    input  logic fpu_64,
    input  logic vu_en,
    input  logic in_dslot,
    output logic rsvd,
    output logic vudis
);
    logic fmode_bad;

    // Resolve the exceptions in fixed priority order.
    always_comb begin
        fmode_bad = fpu_en && !fpu_64;
        vudis     = !fmode_bad && !vu_en;
        rsvd      = fmode_bad || (vu_en && in_dslot);
    end
endmodule

// File: rtl/vbr_target.sv
`timescale 1ns/1ps
// Branch target adder: pc + 4 + sign-extended word offset shifted by two.
// Assumes PC_W > OFF_W + 2. The sum wraps at 2^PC_W.
module vbr_target #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 10
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] off,
    output logic [PC_W-1:0]  target
);
    logic [PC_W-1:0] off_ext;

    // Sign-extend the offset, scale it to bytes and add it to the next PC.
    always_comb begin
        off_ext = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
        target  = pc + PC_W'(4) + {off_ext[PC_W-3:0], 2'b00};
    end
endmodule

// File: rtl/vbr_cond_eval.sv
`timescale 1ns/1ps
// Vector branch condition evaluator (top).
// Combines the whole-vector test, the per-lane zero test, the legality guard
// and the target adder. OUT_REG selects a same-cycle or a one-cycle
// registered result. Assumes VEC_W is twice the half width and that the
// half width is a multiple of 64.
module vbr_cond_eval #(
    parameter int VEC_W   = 128,
    parameter int PC_W    = 32,
    parameter int OFF_W   = 10,
    parameter bit OUT_REG = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dec_stb,
    input  logic [VEC_W/2-1:0]   vec_lo,
    input  logic [VEC_W/2-1:0]   vec_hi,
    input  logic [1:0]           br_kind,
    input  logic [1:0]           elem_fmt,
    input  logic [OFF_W-1:0]     br_off,
    input  logic [PC_W-1:0]      pc,
    input  logic                 vu_en,
    input  logic                 fpu_en,
    input  logic                 fpu_64,
    input  logic                 in_dslot,
    output logic                 res_valid,
    output logic                 br_taken,
    output logic [PC_W-1:0]      br_target,
    output logic                 dslot_req,
    output logic                 exc_rsvd,
    output logic                 exc_vudis
);
    import vbr_pkg::*;

    localparam int HALF_W = VEC_W / 2;

    logic            lo_zero_lane;
    logic            hi_zero_lane;
    logic            any_zero_lane;
    logic            vec_all_zero;
    logic            cond;
    logic            g_rsvd;
    logic            g_vudis;
    logic [PC_W-1:0] tgt;
    br_flags_t       nxt;

    vbr_lane_zero #(.HALF_W(HALF_W)) u_lz_lo (
        .half(vec_lo), .fmt(elem_fmt), .any_zero(lo_zero_lane)
    );

    vbr_lane_zero #(.HALF_W(HALF_W)) u_lz_hi (
        .half(vec_hi), .fmt(elem_fmt), .any_zero(hi_zero_lane)
    );

    vbr_guard u_guard (
        .fpu_en(fpu_en), .fpu_64(fpu_64), .vu_en(vu_en),
        .in_dslot(in_dslot), .rsvd(g_rsvd), .vudis(g_vudis)
    );

    vbr_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
        .pc(pc), .off(br_off), .target(tgt)
    );

    // Pick the branch condition for the requested kind.
    always_comb begin
        any_zero_lane = lo_zero_lane || hi_zero_lane;
        vec_all_zero  = ~|(vec_lo | vec_hi);
        unique case (br_kind_e'(br_kind))
            BK_VEC_ZERO:   cond = vec_all_zero;
            BK_VEC_NZ:     cond = !vec_all_zero;
            BK_LANE_ZERO:  cond = any_zero_lane;
            BK_LANE_ALLNZ: cond = !any_zero_lane;
            default:       cond = 1'b0;
        endcase
    end

    // Suppress the branch and the delay slot when an exception is raised.
    always_comb begin
        nxt.rsvd  = g_rsvd;
        nxt.vudis = g_vudis;
        nxt.dslot = !(g_rsvd || g_vudis);
        nxt.taken = cond && nxt.dslot;
    end

    if (OUT_REG) begin : g_reg
        br_flags_t       q_flags;
        logic [PC_W-1:0] q_tgt;
        logic            q_vld;

        // Capture the decision on the strobe and present it a cycle later.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_vld   <= 1'b0;
                q_flags <= '0;
                q_tgt   <= '0;
            end else begin
                q_vld <= dec_stb;
                if (dec_stb) begin
                    q_flags <= nxt;
                    q_tgt   <= tgt;
                end
            end
        end

        // Drive the ports from the capture registers.
        always_comb begin
            res_valid = q_vld;
            br_taken  = q_flags.taken;
            dslot_req = q_flags.dslot;
            exc_rsvd  = q_flags.rsvd;
            exc_vudis = q_flags.vudis;
            br_target = q_tgt;
        end
    end else begin : g_comb
        // Drive the ports straight from the evaluation logic.
        always_comb begin
            res_valid = dec_stb;
            br_taken  = nxt.taken;
            dslot_req = nxt.dslot;
            exc_rsvd  = nxt.rsvd;
            exc_vudis = nxt.vudis;
            br_target = tgt;
        end
    end
endmodule

// File: rtl/vbr_chk.sv
`timescale 1ns/1ps
// Assertion checker for vbr_cond_eval, attached to it with a bind.
// Relates the outputs to the status inputs. For the registered variant
// the inputs are taken one cycle in the past.
module vbr_chk #(
    parameter bit OUT_REG = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic dec_stb,
    input logic fpu_en,
    input logic fpu_64,
    input logic vu_en,
    input logic in_dslot,
    input logic res_valid,
    input logic br_taken,
    input logic dslot_req,
    input logic exc_rsvd,
    input logic exc_vudis
);
    // R9
    exc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_rsvd, exc_vudis}));

    // R9
    exc_blocks_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_rsvd || exc_vudis) |-> (!br_taken && !dslot_req));

    // R10
    clean_sets_dslot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !exc_rsvd && !exc_vudis) |-> dslot_req);

    if (OUT_REG) begin : g_reg_chk
        // R11
        valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dec_stb |=> res_valid);

        // R11
        valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !dec_stb |=> !res_valid);

        // R6
        fpu_mode_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_stb && fpu_en && !fpu_64) |=> exc_rsvd);

        // R7
        unit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_stb && !(fpu_en && !fpu_64) && !vu_en) |=> exc_vudis);

        // R8
        dslot_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_stb && !(fpu_en && !fpu_64) && vu_en && in_dslot) |=> exc_rsvd);
    end else begin : g_comb_chk
        // R11
        valid_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid == dec_stb);

        // R6
        fpu_mode_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fpu_en && !fpu_64) |-> exc_rsvd);

        // R7
        unit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!(fpu_en && !fpu_64) && !vu_en) |-> exc_vudis);

        // R8
        dslot_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!(fpu_en && !fpu_64) && vu_en && in_dslot) |-> exc_rsvd);
    end
endmodule

bind vbr_cond_eval vbr_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk(clk), .rst_n(rst_n), .dec_stb(dec_stb),
    .fpu_en(fpu_en), .fpu_64(fpu_64), .vu_en(vu_en), .in_dslot(in_dslot),
    .res_valid(res_valid), .br_taken(br_taken), .dslot_req(dslot_req),
    .exc_rsvd(exc_rsvd), .exc_vudis(exc_vudis)
);

// File: tb/sim_vbr_cond_eval.sv
`timescale 1ns/1ps
// Bench: u0 is the registered variant, u1 the combinational one; both see
// the same stimulus. Expected values come from the bench model functions.
module sim_vbr_cond_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_stb = 1'b0;
    logic [63:0] vec_lo = '0, vec_hi = '0;
    logic [1:0]  br_kind = '0, elem_fmt = '0;
    logic [9:0]  br_off = '0;
    logic [31:0] pc = '0;
    logic        vu_en = 1'b1, fpu_en = 1'b0, fpu_64 = 1'b1, in_dslot = 1'b0;

    logic        v0, t0, d0, r0, u0x, v1, t1, d1, r1, u1x;
    logic [31:0] g0, g1;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vbr_cond_eval #(.OUT_REG(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .dec_stb(dec_stb), .vec_lo(vec_lo),
        .vec_hi(vec_hi), .br_kind(br_kind), .elem_fmt(elem_fmt),
        .br_off(br_off), .pc(pc), .vu_en(vu_en), .fpu_en(fpu_en),
        .fpu_64(fpu_64), .in_dslot(in_dslot), .res_valid(v0),
        .br_taken(t0), .br_target(g0), .dslot_req(d0), .exc_rsvd(r0),
        .exc_vudis(u0x)
    );

    vbr_cond_eval #(.OUT_REG(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .dec_stb(dec_stb), .vec_lo(vec_lo),
        .vec_hi(vec_hi), .br_kind(br_kind), .elem_fmt(elem_fmt),
        .br_off(br_off), .pc(pc), .vu_en(vu_en), .fpu_en(fpu_en),
        .fpu_64(fpu_64), .in_dslot(in_dslot), .res_valid(v1),
        .br_taken(t1), .br_target(g1), .dslot_req(d1), .exc_rsvd(r1),
        .exc_vudis(u1x)
    );

    task automatic chk(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Model: does any lane of width 8<<fmt hold all zeros?
    function automatic bit m_zero_lane(input logic [127:0] v, input int fmt);
        int w = 8 << fmt;
        logic [127:0] msk = (128'd1 << w) - 128'd1;
        for (int i = 0; i < 128 / w; i++) begin
            if (((v >> (i * w)) & msk) == 128'd0) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic bit m_cond(input logic [127:0] v, input int kind,
                                  input int fmt);
        case (kind)
            0: return v == 128'd0;
            1: return v != 128'd0;
            2: return m_zero_lane(v, fmt);
            default: return !m_zero_lane(v, fmt);
        endcase
    endfunction

    function automatic string kind_tag(input int kind);
        case (kind)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [127:0] rand_vec();
        logic [127:0] v;
        if ($urandom % 8 == 0) return '0;
        for (int b = 0; b < 16; b++) begin
            v[b*8 +: 8] = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
        end
        return v;
    endfunction

    // Compare one variant's outputs with the model.
    task automatic cmp(input string who, input logic vld, input logic tk,
                       input logic [31:0] tg, input logic ds, input logic rs,
                       input logic ud, input logic [127:0] v, input int kind,
                       input int fmt, input logic [9:0] off,
                       input logic [31:0] p, input bit fe, input bit f64,
                       input bit ve, input bit dsl);
        bit fbad = fe && !f64;
        bit e_ud = !fbad && !ve;
        bit e_rs = fbad || (ve && dsl);
        bit e_any = e_ud || e_rs;
        logic [31:0] e_tg = p + 32'd4 + (32'(signed'(off)) << 2);
        chk({who, " R11 valid"}, 64'(vld), 64'd1);
        chk({who, " ", e_any ? "R9" : kind_tag(kind), " taken"}, 64'(tk),
            64'(!e_any && m_cond(v, kind, fmt)));
        chk({who, " R5 target"}, 64'(tg), 64'(e_tg));
        chk({who, " R10 dslot"}, 64'(ds), 64'(!e_any));
        chk({who, fbad ? " R6 rsvd" : " R8 rsvd"}, 64'(rs), 64'(e_rs));
        chk({who, " R7 vudis"}, 64'(ud), 64'(e_ud));
    endtask

    task automatic run_case(input logic [127:0] v, input int kind,
                            input int fmt, input logic [9:0] off,
                            input logic [31:0] p, input bit fe, input bit f64,
                            input bit ve, input bit dsl);
        @(negedge clk);
        {vec_hi, vec_lo} = v;
        br_kind = 2'(kind); elem_fmt = 2'(fmt); br_off = off; pc = p;
        fpu_en = fe; fpu_64 = f64; vu_en = ve; in_dslot = dsl;
        dec_stb = 1'b1;
        #1;
        cmp("comb", v1, t1, g1, d1, r1, u1x, v, kind, fmt, off, p, fe, f64, ve, dsl);
        @(negedge clk);
        dec_stb = 1'b0;
        cmp("reg", v0, t0, g0, d0, r0, u0x, v, kind, fmt, off, p, fe, f64, ve, dsl);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        // R12: registered outputs are cleared while reset is held
        chk("reg R12 reset valid", 64'(v0), 64'd0);
        chk("reg R12 reset outs", 64'({t0, d0, r0, u0x, g0}), 64'd0);
        rst_n = 1'b1;

        // Directed corner cases, one per requirement.
        run_case('0, 0, 0, 10'd0, 32'h1000, 0, 1, 1, 0);                    // R1
        run_case(128'd1 << 127, 0, 0, 10'd0, 32'h1000, 0, 1, 1, 0);         // R1
        run_case(128'd1 << 127, 1, 0, 10'd0, 32'h1000, 0, 1, 1, 0);         // R2
        run_case('0, 1, 3, 10'd0, 32'h1000, 0, 1, 1, 0);                    // R2
        run_case({64'h0101010101010101, 64'h01010101010100FF}, 2, 0,
                 10'd1, 32'h2000, 0, 1, 1, 0);                              // R3
        run_case({64'h0001000100010001, 64'h0001000100010100}, 2, 1,
                 10'd1, 32'h2000, 0, 1, 1, 0);                              // R3
        run_case({64'h1, 64'h0000000100000000}, 3, 2, 10'd1, 32'h2000,
                 0, 1, 1, 0);                                               // R4
        run_case({64'h0, 64'h8000000000000000}, 3, 3, 10'd1, 32'h2000,
                 0, 1, 1, 0);                                               // R4
        run_case({64'h1, 64'hFFFFFFFFFFFFFFFF}, 3, 3, 10'd1, 32'h2000,
                 0, 1, 1, 0);                                               // R4
        run_case('1, 1, 0, 10'h200, 32'h1000, 0, 1, 1, 0);                  // R5
        run_case('1, 1, 0, 10'h1FF, 32'hFFFFFFFC, 0, 1, 1, 0);              // R5
        run_case('0, 0, 0, 10'd3, 32'h40, 1, 0, 0, 1);                      // R6
        run_case('0, 0, 0, 10'd3, 32'h40, 1, 1, 0, 1);                      // R7
        run_case('0, 0, 0, 10'd3, 32'h40, 0, 0, 1, 1);                      // R8
        run_case('1, 1, 0, 10'd3, 32'h40, 0, 1, 1, 0);                      // R10

        // R11: with no strobe the registered result is not valid
        @(negedge clk);
        chk("reg R11 idle valid", 64'(v0), 64'd0);
        chk("comb R11 idle valid", 64'(v1), 64'd0);

        // Constrained random mix.
        for (int n = 0; n < 600; n++) begin
            run_case(rand_vec(), int'($urandom % 4), int'($urandom % 4),
                     10'($urandom), $urandom,
                     ($urandom % 4) == 0, ($urandom % 6) != 0,
                     ($urandom % 10) != 0, ($urandom % 8) == 0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule